// File: doc/BRIEF.md
# Port-control microsequencer

This block runs short programs of 32-bit microinstructions out of its own instruction store and uses them to drive a byte-wide parallel-port register file. It reads and writes that register file through a select and strobe interface. It tests the port's status lines directly for branch decisions. It moves bytes between the port registers and a small local byte buffer. Timed waits come from a microsecond prescaler.

A host loads the instruction store and the buffer while the engine is idle. It then pulses `start_i` with an entry address. The engine executes one instruction per cycle, except for delays and repeated transfers. A program ends on a return instruction, which reports an 8-bit code. An illegal instruction ends it with an error instead. A subroutine call can enter one subroutine; a second level of call is refused.

Top module: `msq_engine`

## Requirements
- R1: Instruction encoding. The opcode is in bits [31:27] and the register select in [25:24]. Register select values are 0 = data, 1 = status, 2 = control and 3 = spare. Field A is in [23:16], field B in [15:8] and field C in [7:0]. The opcodes are: 1 write-immediate, 2 set/clear, 3 fetch, 4 delay, 5 load counter, 6 decrement-and-branch, 7 branch-if-any-set, 8 branch-if-any-clear, 9 branch-on-state, 10 return, 11 load pointer, 12 call, 13 subroutine return, 14 repeated write, 15 repeated fetch.
- R2: Write-immediate writes A to the selected register. Set/clear reads the selected register and, in the same cycle, writes back (value OR A) AND NOT B.
- R3: Fetch stores (selected register AND A) into the buffer at the current pointer and leaves the pointer unchanged. Load pointer sets the pointer to A.
- R4: Load counter sets the 8-bit branch counter to A. Decrement-and-branch stores counter-1 and branches only when that result, read as a signed byte, is greater than zero. Every branch target is (own address + 1) + signed C.
- R5: Branch-if-any-set branches when any status bit selected by A is 1. Branch-if-any-clear branches when any status bit selected by A is 0.
- R6: Branch-on-state branches only when every status bit in A is 1 and every status bit in B is 0.
- R7: Return gives a one-cycle `done_o` with `ret_code_o` = A and `err_o` = 0, and the engine goes idle.
- R8: A delay with A > 0 stalls for A*CLK_PER_US cycles, so the next instruction executes A*CLK_PER_US+1 cycles after the delay instruction. A delay with A = 0 does not stall.
- R9: Call saves (own address + 1) and jumps to address A. Subroutine return resumes at the saved address.
- R10: A call made inside a subroutine, a subroutine return outside one, or an opcode of 0 or above 15 ends the program. It gives a `done_o` pulse with `err_o` = 1 and `ret_code_o` = 0xFF, and no further register access follows.
- R11: A repeated write or repeated fetch performs A accesses, one per cycle, and the pointer advances by one after each. A repeated write sends buffer bytes; a repeated fetch stores (register AND B). With A = 0 no access is made.
- R12: After reset the engine is idle with `busy_o`, `done_o`, `err_o` and both strobes low. A `start_i` pulse while idle begins execution at `start_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_we_i | input | 1 | Instruction store write enable |
| prog_addr_i | input | log2(IMEM_DEPTH) | Instruction store write address |
| prog_data_i | input | 32 | Instruction word to store |
| host_buf_we_i | input | 1 | Host write enable into the byte buffer |
| host_buf_addr_i | input | log2(BUF_DEPTH) | Host buffer address |
| host_buf_wdata_i | input | 8 | Host buffer write data |
| host_buf_rdata_o | output | 8 | Buffer byte at the host address |
| start_i | input | 1 | Start pulse, honoured when idle |
| start_addr_i | input | log2(IMEM_DEPTH) | Entry address |
| status_i | input | 8 | Port status lines used by branches |
| reg_sel_o | output | 2 | Port register select |
| reg_wr_o | output | 1 | Port register write strobe |
| reg_rd_o | output | 1 | Port register read strobe |
| reg_wdata_o | output | 8 | Port register write data |
| reg_rdata_i | input | 8 | Port register read data, valid in the strobe cycle |
| busy_o | output | 1 | Program executing |
| done_o | output | 1 | One-cycle end-of-program pulse |
| err_o | output | 1 | Last program ended on an error |
| ret_code_o | output | 8 | Code of the last program |

## Verification
The hardest case to reach is the decrement-and-branch boundary. Here the counter's decremented value is zero or has its top bit set, so the loop must exit even though the unsigned value is large. The bench reaches it by loading counters of 0, 1, 3 and 200 ahead of a one-write loop and counting the strobes each run produces. The refused second call is reached by a program whose subroutine calls another. Exact delay length is measured as the cycle gap between two marker writes placed around the delay.

// File: rtl/msq_pkg.sv
package msq_pkg;
  localparam int INSTR_W = 32;
  localparam int OP_W    = 5;

  localparam logic [OP_W-1:0] OP_WR     = 5'd1;
  localparam logic [OP_W-1:0] OP_RSET   = 5'd2;
  localparam logic [OP_W-1:0] OP_RFETCH = 5'd3;
  localparam logic [OP_W-1:0] OP_DELAY  = 5'd4;
  localparam logic [OP_W-1:0] OP_SET    = 5'd5;
  localparam logic [OP_W-1:0] OP_DBRA   = 5'd6;
  localparam logic [OP_W-1:0] OP_BRSET  = 5'd7;
  localparam logic [OP_W-1:0] OP_BRCLR  = 5'd8;
  localparam logic [OP_W-1:0] OP_BRSTAT = 5'd9;
  localparam logic [OP_W-1:0] OP_RET    = 5'd10;
  localparam logic [OP_W-1:0] OP_PTR    = 5'd11;
  localparam logic [OP_W-1:0] OP_CALL   = 5'd12;
  localparam logic [OP_W-1:0] OP_SUBRET = 5'd13;
  localparam logic [OP_W-1:0] OP_WRP    = 5'd14;
  localparam logic [OP_W-1:0] OP_RDP    = 5'd15;
  localparam logic [OP_W-1:0] OP_LAST   = OP_RDP;

  localparam logic [7:0] ERR_CODE = 8'hFF;

  typedef struct packed {
    logic [OP_W-1:0] op;
    logic            rsv;
    logic [1:0]      rsel;
    logic [7:0]      a;
    logic [7:0]      b;
    logic [7:0]      c;
  } instr_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_WAIT,
    ST_REP
  } state_e;
endpackage

// File: rtl/msq_imem.sv
module msq_imem #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/msq_bytebuf.sv
module msq_bytebuf #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  // engine port, wins on an address collision
  input  logic          eng_we_i,
  input  logic [AW-1:0] eng_addr_i,
  input  logic [7:0]    eng_wdata_i,
  output logic [7:0]    eng_rdata_o,
  // host port
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [7:0]    host_wdata_i,
  output logic [7:0]    host_rdata_o
);
  logic [7:0] mem [DEPTH];
  logic       host_ok;

  assign host_ok = host_we_i && !(eng_we_i && (eng_addr_i == host_addr_i));

  always_ff @(posedge clk_i) begin
    if (host_ok)  mem[host_addr_i] <= host_wdata_i;
    if (eng_we_i) mem[eng_addr_i]  <= eng_wdata_i;
  end

  assign eng_rdata_o  = mem[eng_addr_i];
  assign host_rdata_o = mem[host_addr_i];
endmodule

// File: rtl/msq_branch_unit.sv
module msq_branch_unit
  import msq_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic [7:0]      status_i,
  input  logic [7:0]      mask_a_i,
  input  logic [7:0]      mask_b_i,
  input  logic [7:0]      bcnt_i,
  output logic [7:0]      bcnt_dec_o,
  output logic            take_o
);
  logic any_set, any_clr, all_state, dec_pos;

  assign bcnt_dec_o = bcnt_i - 8'd1;
  // signed-positive: sign bit clear and nonzero
  assign dec_pos    = !bcnt_dec_o[7] && (bcnt_dec_o != 8'd0);
  assign any_set    = |(status_i & mask_a_i);
  assign any_clr    = |(~status_i & mask_a_i);
  assign all_state  = ((status_i & mask_a_i) == mask_a_i) &&
                      ((~status_i & mask_b_i) == mask_b_i);

  always_comb begin
    case (op_i)
      OP_DBRA:   take_o = dec_pos;
      OP_BRSET:  take_o = any_set;
      OP_BRCLR:  take_o = any_clr;
      OP_BRSTAT: take_o = all_state;
      default:   take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/msq_delay_timer.sv
module msq_delay_timer #(
  parameter int CLK_PER_US = 200,
  parameter int US_W       = 8,
  localparam int PW        = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [US_W-1:0] us_i,
  output logic            active_o,
  output logic            done_o
);
  localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

  logic [PW-1:0]   presc;
  logic [US_W-1:0] us_left;
  logic            active;
  logic            tick;

  assign tick   = active && (presc == LAST);
  assign done_o = tick && (us_left == US_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc   <= '0;
      us_left <= '0;
      active  <= 1'b0;
    end else if (load_i) begin
      presc   <= '0;
      us_left <= us_i;
      active  <= (us_i != '0);
    end else if (active) begin
      if (tick) begin
        presc   <= '0;
        us_left <= us_left - US_W'(1);
        if (us_left == US_W'(1)) active <= 1'b0;
      end else begin
        presc <= presc + PW'(1);
      end
    end
  end

  assign active_o = active;

  a_r8_left_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> (us_left != '0));
  a_r8_presc_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |=> (presc <= LAST));
endmodule

// File: rtl/msq_engine.sv
module msq_engine
  import msq_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int BUF_DEPTH  = 16,
  parameter int CLK_PER_US = 200
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          prog_we_i,
  input  logic [$clog2(IMEM_DEPTH)-1:0] prog_addr_i,
  input  logic [INSTR_W-1:0]            prog_data_i,
  input  logic                          host_buf_we_i,
  input  logic [$clog2(BUF_DEPTH)-1:0]  host_buf_addr_i,
  input  logic [7:0]                    host_buf_wdata_i,
  output logic [7:0]                    host_buf_rdata_o,
  input  logic                          start_i,
  input  logic [$clog2(IMEM_DEPTH)-1:0] start_addr_i,
  input  logic [7:0]                    status_i,
  output logic [1:0]                    reg_sel_o,
  output logic                          reg_wr_o,
  output logic                          reg_rd_o,
  output logic [7:0]                    reg_wdata_o,
  input  logic [7:0]                    reg_rdata_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          err_o,
  output logic [7:0]                    ret_code_o
);
  localparam int PC_W = $clog2(IMEM_DEPTH);
  localparam int BA_W = $clog2(BUF_DEPTH);

  state_e          state;
  logic [PC_W-1:0] pc, ret_pc, pc_inc, br_tgt;
  logic            in_sub;
  logic [7:0]      bcnt, bcnt_dec, rep_left;
  logic [BA_W-1:0] ptr;
  logic            done_q, err_q;
  logic [7:0]      code_q;

  logic [INSTR_W-1:0] imem_rdata;
  instr_t             ins;
  logic               run, rep, take, abort, op_valid;
  logic               tmr_load, tmr_active, tmr_done;
  logic               eng_we;
  logic [7:0]         eng_wdata, eng_rdata;

  msq_imem #(.DEPTH(IMEM_DEPTH), .WIDTH(INSTR_W)) u_imem (
    .clk_i   (clk_i),
    .we_i    (prog_we_i),
    .waddr_i (prog_addr_i),
    .wdata_i (prog_data_i),
    .raddr_i (pc),
    .rdata_o (imem_rdata)
  );

  assign ins = instr_t'(imem_rdata);
  assign run = (state == ST_RUN);
  assign rep = (state == ST_REP);

  msq_branch_unit u_branch (
    .op_i       (ins.op),
    .status_i   (status_i),
    .mask_a_i   (ins.a),
    .mask_b_i   (ins.b),
    .bcnt_i     (bcnt),
    .bcnt_dec_o (bcnt_dec),
    .take_o     (take)
  );

  assign tmr_load = run && (ins.op == OP_DELAY) && (ins.a != 8'd0);

  msq_delay_timer #(.CLK_PER_US(CLK_PER_US), .US_W(8)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .us_i     (ins.a),
    .active_o (tmr_active),
    .done_o   (tmr_done)
  );

  // byte buffer: engine writes on fetches, reads on repeated writes
  assign eng_we    = (run && (ins.op == OP_RFETCH)) || (rep && (ins.op == OP_RDP));
  assign eng_wdata = reg_rdata_i & ((ins.op == OP_RDP) ? ins.b : ins.a);

  msq_bytebuf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk_i        (clk_i),
    .eng_we_i     (eng_we),
    .eng_addr_i   (ptr),
    .eng_wdata_i  (eng_wdata),
    .eng_rdata_o  (eng_rdata),
    .host_we_i    (host_buf_we_i),
    .host_addr_i  (host_buf_addr_i),
    .host_wdata_i (host_buf_wdata_i),
    .host_rdata_o (host_buf_rdata_o)
  );

  assign pc_inc   = pc + PC_W'(1);
  assign br_tgt   = pc_inc + PC_W'($signed(ins.c));
  assign op_valid = (ins.op != '0) && (ins.op <= OP_LAST);
  assign abort    = run && (!op_valid ||
                            ((ins.op == OP_CALL)   &&  in_sub) ||
                            ((ins.op == OP_SUBRET) && !in_sub));

  // port register strobes
  assign reg_sel_o = ins.rsel;
  assign reg_wr_o  = (run && ((ins.op == OP_WR) || (ins.op == OP_RSET))) ||
                     (rep && (ins.op == OP_WRP));
  assign reg_rd_o  = (run && ((ins.op == OP_RSET) || (ins.op == OP_RFETCH))) ||
                     (rep && (ins.op == OP_RDP));

  always_comb begin
    reg_wdata_o = 8'd0;
    if (run) begin
      case (ins.op)
        OP_WR:   reg_wdata_o = ins.a;
        OP_RSET: reg_wdata_o = (reg_rdata_i | ins.a) & ~ins.b;
        default: reg_wdata_o = 8'd0;
      endcase
    end else if (rep && (ins.op == OP_WRP)) begin
      reg_wdata_o = eng_rdata;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      pc       <= '0;
      ret_pc   <= '0;
      in_sub   <= 1'b0;
      bcnt     <= 8'd0;
      ptr      <= '0;
      rep_left <= 8'd0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      code_q   <= 8'd0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            pc     <= start_addr_i;
            in_sub <= 1'b0;
            err_q  <= 1'b0;
            state  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (abort) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
            code_q <= ERR_CODE;
            state  <= ST_IDLE;
          end else begin
            case (ins.op)
              OP_DELAY: begin
                if (ins.a == 8'd0) pc <= pc_inc;
                else               state <= ST_WAIT;
              end
              OP_SET: begin
                bcnt <= ins.a;
                pc   <= pc_inc;
              end
              OP_DBRA: begin
                bcnt <= bcnt_dec;
                pc   <= take ? br_tgt : pc_inc;
              end
              OP_BRSET, OP_BRCLR, OP_BRSTAT: pc <= take ? br_tgt : pc_inc;
              OP_RET: begin
                done_q <= 1'b1;
                code_q <= ins.a;
                state  <= ST_IDLE;
              end
              OP_PTR: begin
                ptr <= BA_W'(ins.a);
                pc  <= pc_inc;
              end
              OP_CALL: begin
                ret_pc <= pc_inc;
                in_sub <= 1'b1;
                pc     <= PC_W'(ins.a);
              end
              OP_SUBRET: begin
                pc     <= ret_pc;
                in_sub <= 1'b0;
              end
              OP_WRP, OP_RDP: begin
                if (ins.a == 8'd0) begin
                  pc <= pc_inc;
                end else begin
                  rep_left <= ins.a;
                  state    <= ST_REP;
                end
              end
              default: pc <= pc_inc;
            endcase
          end
        end
        ST_WAIT: begin
          if (tmr_done) begin
            pc    <= pc_inc;
            state <= ST_RUN;
          end
        end
        ST_REP: begin
          ptr      <= ptr + BA_W'(1);
          rep_left <= rep_left - 8'd1;
          if (rep_left == 8'd1) begin
            pc    <= pc_inc;
            state <= ST_RUN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign ret_code_o = code_q;

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_ret_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && (ins.op == OP_RET)) |=> (done_o && !err_o && (ret_code_o == $past(ins.a))));
  a_r4_dbra_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && (ins.op == OP_DBRA)) |=> (bcnt == $past(bcnt) - 8'd1));
  a_r8_wait_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state == ST_WAIT) && !tmr_done) |=> ((state == ST_WAIT) && $stable(pc)));
  a_r8_timer_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT) |-> tmr_active);
  a_r10_nested_call: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && (ins.op == OP_CALL) && in_sub) |=> (done_o && err_o && !busy_o));
  a_r11_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep |=> (ptr == $past(ptr) + BA_W'(1)));
  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!reg_wr_o && !reg_rd_o));
endmodule

// File: tb/msq_engine_tb.sv
`timescale 1ns/1ps
module msq_engine_tb;
  localparam int CPU = 200;

  localparam logic [4:0] WR = 5'd1, RSET = 5'd2, RFETCH = 5'd3, DELAY = 5'd4,
                         SET = 5'd5, DBRA = 5'd6, BRSET = 5'd7, BRCLR = 5'd8,
                         BRSTAT = 5'd9, RET = 5'd10, PTR = 5'd11, CALL = 5'd12,
                         SUBRET = 5'd13, WRP = 5'd14, RDP = 5'd15;
  localparam logic [1:0] S_DATA = 2'd0, S_STAT = 2'd1, S_CTRL = 2'd2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prog_we = 1'b0;
  logic [5:0] prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic       hb_we = 1'b0;
  logic [3:0] hb_addr = '0;
  logic [7:0] hb_wdata = '0;
  logic [7:0] hb_rdata;
  logic       start = 1'b0;
  logic [5:0] start_addr = '0;
  logic [7:0] stat = '0;
  logic [1:0] reg_sel;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       busy, done, err;
  logic [7:0] code;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [7:0] r_data, r_ctrl, r_aux;
  int         wr_cnt;
  int         wr_time [64];
  logic [1:0] wr_sel  [64];
  logic [7:0] wr_val  [64];

  always #2.5 clk = ~clk;

  msq_engine u_dut (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .prog_we_i        (prog_we),
    .prog_addr_i      (prog_addr),
    .prog_data_i      (prog_data),
    .host_buf_we_i    (hb_we),
    .host_buf_addr_i  (hb_addr),
    .host_buf_wdata_i (hb_wdata),
    .host_buf_rdata_o (hb_rdata),
    .start_i          (start),
    .start_addr_i     (start_addr),
    .status_i         (stat),
    .reg_sel_o        (reg_sel),
    .reg_wr_o         (reg_wr),
    .reg_rd_o         (reg_rd),
    .reg_wdata_o      (reg_wdata),
    .reg_rdata_i      (reg_rdata),
    .busy_o           (busy),
    .done_o           (done),
    .err_o            (err),
    .ret_code_o       (code)
  );

  // port register model
  always_comb begin
    case (reg_sel)
      S_DATA:  reg_rdata = r_data;
      S_STAT:  reg_rdata = stat;
      S_CTRL:  reg_rdata = r_ctrl;
      default: reg_rdata = r_aux;
    endcase
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      r_data <= '0; r_ctrl <= '0; r_aux <= '0; wr_cnt <= 0;
    end else if (reg_wr) begin
      case (reg_sel)
        S_DATA:  r_data <= reg_wdata;
        S_CTRL:  r_ctrl <= reg_wdata;
        2'd3:    r_aux  <= reg_wdata;
        default: ;
      endcase
      wr_time[wr_cnt % 64] <= cyc;
      wr_sel[wr_cnt % 64]  <= reg_sel;
      wr_val[wr_cnt % 64]  <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  function automatic logic [31:0] mk(input logic [4:0] op, input logic [1:0] rs,
                                     input logic [7:0] a, input logic [7:0] b,
                                     input logic [7:0] c);
    return {op, 1'b0, rs, a, b, c};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ld(input int addr, input logic [31:0] w);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = addr[5:0]; prog_data = w;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic hb_put(input int addr, input logic [7:0] v);
    @(negedge clk);
    hb_we = 1'b1; hb_addr = addr[3:0]; hb_wdata = v;
    @(negedge clk);
    hb_we = 1'b0;
  endtask

  task automatic hb_get(input int addr, output logic [7:0] v);
    @(negedge clk);
    hb_addr = addr[3:0];
    #1 v = hb_rdata;
  endtask

  task automatic run(input int entry, output logic [7:0] rc, output logic re);
    bit got = 0;
    @(negedge clk);
    start = 1'b1; start_addr = entry[5:0];
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
    rc = code; re = err;
    check("R7 program completes", int'(got), 1);
  endtask

  task automatic t_reset();
    check("R12 busy after reset", int'(busy), 0);
    check("R12 done after reset", int'(done), 0);
    check("R12 err after reset", int'(err), 0);
    check("R12 strobes after reset", int'({reg_wr, reg_rd}), 0);
  endtask

  task automatic t_rset();
    logic [7:0] rc; logic re; int w0;
    ld(0, mk(WR, S_CTRL, 8'hF0, 0, 0));
    ld(1, mk(RSET, S_CTRL, 8'h0F, 8'h30, 0));
    ld(2, mk(RET, 0, 8'h05, 0, 0));
    w0 = wr_cnt;
    run(0, rc, re);
    check("R2 set/clear result", int'(r_ctrl), 'hCF);
    check("R2 write count", wr_cnt - w0, 2);
    check("R7 return code", int'(rc), 5);
    check("R7 no error", int'(re), 0);
    check("R12 idle after return", int'(busy), 0);
  endtask

  task automatic t_rfetch();
    logic [7:0] rc, v; logic re;
    hb_put(4, 8'h77);
    stat = 8'hA5;
    ld(0, mk(PTR, 0, 8'd3, 0, 0));
    ld(1, mk(RFETCH, S_STAT, 8'h0F, 0, 0));
    ld(2, mk(WRP, S_DATA, 8'd1, 0, 0));
    ld(3, mk(RET, 0, 8'd0, 0, 0));
    run(0, rc, re);
    hb_get(3, v);
    check("R3 fetched byte", int'(v), 'h05);
    check("R3 pointer unchanged after fetch", int'(r_data), 'h05);
    hb_get(4, v);
    check("R3 neighbour untouched", int'(v), 'h77);
    check("R1 field decode for fetch", int'(rc), 0);
  endtask

  task automatic t_dbra(input logic [7:0] n, input int exp_w);
    logic [7:0] rc; logic re; int w0;
    ld(0, mk(SET, 0, n, 0, 0));
    ld(1, mk(WR, S_DATA, 8'h11, 0, 0));
    ld(2, mk(DBRA, 0, 0, 0, 8'hFE));
    ld(3, mk(RET, 0, 8'h09, 0, 0));
    w0 = wr_cnt;
    run(0, rc, re);
    check($sformatf("R4 loop writes for counter %0d", n), wr_cnt - w0, exp_w);
    check("R4 loop exit return", int'(rc), 9);
  endtask

  task automatic t_branch(input string req, input logic [4:0] op, input logic [7:0] a,
                          input logic [7:0] b, input logic [7:0] st, input int exp_rc);
    logic [7:0] rc; logic re;
    stat = st;
    ld(0, mk(op, 0, a, b, 8'h01));
    ld(1, mk(RET, 0, 8'd1, 0, 0));
    ld(2, mk(RET, 0, 8'd2, 0, 0));
    run(0, rc, re);
    check(req, int'(rc), exp_rc);
  endtask

  task automatic t_delay(input logic [7:0] n);
    logic [7:0] rc; logic re; int w0, gap;
    ld(0, mk(WR, S_DATA, 8'h01, 0, 0));
    ld(1, mk(DELAY, 0, n, 0, 0));
    ld(2, mk(WR, S_DATA, 8'h02, 0, 0));
    ld(3, mk(RET, 0, 0, 0, 0));
    w0 = wr_cnt;
    run(0, rc, re);
    gap = wr_time[(w0 + 1) % 64] - wr_time[w0 % 64];
    check($sformatf("R8 delay gap for %0d us", n), gap, int'(n) * CPU + 2);
  endtask

  task automatic t_call();
    logic [7:0] rc; logic re; int w0;
    ld(0, mk(CALL, 0, 8'd40, 0, 0));
    ld(1, mk(WR, S_DATA, 8'h33, 0, 0));
    ld(2, mk(RET, 0, 8'd7, 0, 0));
    ld(40, mk(WR, S_CTRL, 8'h44, 0, 0));
    ld(41, mk(SUBRET, 0, 0, 0, 0));
    w0 = wr_cnt;
    run(0, rc, re);
    check("R9 subroutine write first", int'(wr_sel[w0 % 64]), int'(S_CTRL));
    check("R9 resume after call", int'(wr_sel[(w0 + 1) % 64]), int'(S_DATA));
    check("R9 resumed value", int'(wr_val[(w0 + 1) % 64]), 'h33);
    check("R9 return code", int'(rc), 7);
    check("R9 no error", int'(re), 0);
  endtask

  task automatic t_abort(input string req, input logic [31:0] w0i, input logic [31:0] w1i);
    logic [7:0] rc; logic re; int w0;
    ld(0, mk(WR, S_AUX(), 8'h5A, 0, 0));
    ld(1, w0i);
    ld(2, w1i);
    ld(3, mk(WR, S_DATA, 8'hEE, 0, 0));
    ld(4, mk(RET, 0, 8'd3, 0, 0));
    ld(40, mk(CALL, 0, 8'd50, 0, 0));
    ld(41, mk(SUBRET, 0, 0, 0, 0));
    ld(50, mk(SUBRET, 0, 0, 0, 0));
    w0 = wr_cnt;
    run(0, rc, re);
    check({req, " error flag"}, int'(re), 1);
    check({req, " error code"}, int'(rc), 'hFF);
    check({req, " no access after abort"}, wr_cnt - w0, 1);
  endtask

  function automatic logic [1:0] S_AUX();
    return 2'd3;
  endfunction

  task automatic t_rep();
    logic [7:0] rc, v; logic re; int w0;
    hb_put(4, 8'h21); hb_put(5, 8'h42); hb_put(6, 8'h63);
    ld(0, mk(PTR, 0, 8'd4, 0, 0));
    ld(1, mk(WRP, S_DATA, 8'd3, 0, 0));
    ld(2, mk(RET, 0, 0, 0, 0));
    w0 = wr_cnt;
    run(0, rc, re);
    check("R11 repeated write count", wr_cnt - w0, 3);
    check("R11 first byte", int'(wr_val[w0 % 64]), 'h21);
    check("R11 last byte", int'(wr_val[(w0 + 2) % 64]), 'h63);
    check("R11 back-to-back", wr_time[(w0 + 2) % 64] - wr_time[w0 % 64], 2);

    hb_put(8, 8'hEE); hb_put(9, 8'hEE); hb_put(10, 8'hEE);
    stat = 8'h3C;
    ld(0, mk(PTR, 0, 8'd8, 0, 0));
    ld(1, mk(RDP, S_STAT, 8'd2, 8'hF0, 0));
    ld(2, mk(WRP, S_DATA, 8'd1, 0, 0));
    ld(3, mk(RET, 0, 0, 0, 0));
    run(0, rc, re);
    hb_get(8, v);  check("R11 fetch byte 0", int'(v), 'h30);
    hb_get(9, v);  check("R11 fetch byte 1", int'(v), 'h30);
    hb_get(10, v); check("R11 fetch stops at count", int'(v), 'hEE);
    check("R11 pointer advanced", int'(r_data), 'hEE);

    ld(0, mk(PTR, 0, 8'd0, 0, 0));
    ld(1, mk(WRP, S_DATA, 8'd0, 0, 0));
    ld(2, mk(RET, 0, 8'd4, 0, 0));
    w0 = wr_cnt;
    run(0, rc, re);
    check("R11 zero count no write", wr_cnt - w0, 0);
    check("R11 zero count return", int'(rc), 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rset();
    t_rfetch();
    t_dbra(8'd3, 3);
    t_dbra(8'd1, 1);
    t_dbra(8'd0, 1);
    t_dbra(8'd200, 1);
    t_branch("R5 any-set taken",      BRSET,  8'h80, 8'h00, 8'h80, 2);
    t_branch("R5 any-set not taken",  BRSET,  8'h80, 8'h00, 8'h7F, 1);
    t_branch("R5 any-clear not taken", BRCLR, 8'h81, 8'h00, 8'h81, 1);
    t_branch("R5 any-clear taken",    BRCLR,  8'h81, 8'h00, 8'h01, 2);
    t_branch("R6 state match",        BRSTAT, 8'h0C, 8'h30, 8'h0C, 2);
    t_branch("R6 clear bit set",      BRSTAT, 8'h0C, 8'h30, 8'h1C, 1);
    t_branch("R6 assert bit missing", BRSTAT, 8'h0C, 8'h30, 8'h04, 1);
    t_delay(8'd2);
    t_delay(8'd0);
    t_call();
    t_abort("R10 nested call", mk(CALL, 0, 8'd40, 0, 0), mk(RET, 0, 0, 0, 0));
    t_abort("R10 stray subroutine return", mk(SUBRET, 0, 0, 0, 0), mk(RET, 0, 0, 0, 0));
    t_abort("R10 opcode 31", {5'd31, 27'd0}, mk(RET, 0, 0, 0, 0));
    t_abort("R10 opcode 0", 32'd0, mk(RET, 0, 0, 0, 0));
    t_rep();
    check("R12 idle at end", int'(busy), 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule